// File: doc/BRIEF.md
# Key Matrix Scanner with Two-Scan Confirmation

This block scans a key matrix of six drive lines and five sense inputs, up to thirty keys. It stays idle until a sense input goes high. It then walks the drive lines in order and captures one full picture of the matrix. A second full scan follows. The two pictures are compared, and a key is reported only when both scans agree.

An agreed, non-empty picture is latched into a 30-bit key buffer and a read-request flag is raised for the host interface. A one-cycle read strobe from that interface clears the flag and starts a fresh scan. The block therefore keeps rescanning for as long as any key is held.

A two-bit line-select code gives one or both of the first two drive lines to another use, which shrinks the matrix. A two-bit sleep code chooses which lines are held high while the block waits for a key. A `tick` enable supplies the base period, so all timing is counted in ticks.

Top module: `key_matrix_scanner`

## Requirements
- R1: While idle or waiting for a read, `drive_out` carries the idle pattern for the sleep code, masked by the enabled lines. Code 00 and code 11 drive all six lines high. Code 01 drives only line 6 (bit 5). Code 10 drives lines 5 and 6 (bits 5:4).
- R2: A scan starts on the clock edge after any sense input is high while idle. With no sense input high the block stays idle indefinitely.
- R3: During a scan at most one drive line is high. Lines 1 to 6 (bits 0 to 5) are each driven for 48 ticks in ascending order, and this is done twice. Sense inputs are sampled on the last tick of each slot.
- R4: The key on drive line L (1..6) and sense input S (1..5) sets `key_data` bit (L-1)*5+(S-1).
- R5: When both scans agree and the result is non-zero, `key_data` takes the result and `read_req` rises at the end of the 615th tick after the scan starts.
- R6: When the scans disagree and a sense input is high at the end of the 615th tick, the scan repeats at once, so the request comes 1230 ticks after the first start.
- R7: When the scans disagree and no sense input is high at that point, the block returns to idle without a request and `key_data` is unchanged.
- R8: A `host_read` pulse while `read_req` is high clears `read_req` on the next edge and starts a new scan. A `host_read` pulse with no request pending has no effect.
- R9: When both scans agree on all zeros, `key_data` becomes zero, no request is raised and the block goes idle.
- R10: `line_sel` 00 enables all six lines. Code 01 disables line 2 (bit 1). Codes 10 and 11 disable lines 1 and 2. A disabled line is never driven, and its five key bits read 0.
- R11: `osc_run` is high whenever the sleep code is 00 or a scan, confirmation or pending request is in progress. It is low only when the block is idle in a sleep code.
- R12: Reset clears `key_data` and `read_req` and returns the block to idle.
- R13: Scan and confirmation timing advance only on cycles with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base-period enable |
| sleep_code | input | 2 | Idle drive pattern select; 00 is normal mode |
| line_sel | input | 2 | Matrix size select for drive lines 1 and 2 |
| sense_in | input | 5 | Sense inputs, active high |
| host_read | input | 1 | Read strobe from the host interface |
| drive_out | output | 6 | Drive lines, bit 0 is line 1 |
| key_data | output | 30 | Confirmed key buffer |
| read_req | output | 1 | Key data ready for the host |
| osc_run | output | 1 | Base oscillator should run |

## Verification
The assertions check the following on every cycle:
- a scan never drives more than one line;
- disabled lines stay low;
- normal mode keeps `osc_run` high;
- a rising request always carries non-zero data;
- a read clears the request;
- reset leaves clean outputs.

The following can only be shown by the bench's scenarios:
- the exact 615-tick and 1230-tick request latencies;
- the bit mapping for every key position under each line-select code;
- the disagree-and-release path back to idle;
- sleep codes that ignore a press on an undriven line.

// File: rtl/kms_pkg.sv
package kms_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2,
        ST_WAIT = 2'd3
    } kms_state_e;
endpackage

// File: rtl/kms_line_map.sv
module kms_line_map #(
    parameter int DRIVES = 6
) (
    input  logic [1:0]        line_sel,
    input  logic [1:0]        sleep_code,
    output logic [DRIVES-1:0] line_en,
    output logic [DRIVES-1:0] idle_drive
);
    logic [DRIVES-1:0] pattern;

    // lines 1 and 2 may be handed away; the rest always scan
    for (genvar k = 0; k < DRIVES; k++) begin : g_en
        if (k == 0) begin : g_l1
            assign line_en[k] = ~line_sel[1];
        end else if (k == 1) begin : g_l2
            assign line_en[k] = (line_sel == 2'b00);
        end else begin : g_rest
            assign line_en[k] = 1'b1;
        end
    end

    always_comb begin
        unique case (sleep_code)
            2'b01:   pattern = {1'b1, {(DRIVES-1){1'b0}}};
            2'b10:   pattern = {2'b11, {(DRIVES-2){1'b0}}};
            default: pattern = {DRIVES{1'b1}};
        endcase
        idle_drive = pattern & line_en;
    end
endmodule

// File: rtl/kms_capture.sv
module kms_capture #(
    parameter int DRIVES = 6,
    parameter int SENSES = 5,
    parameter int IDXW   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_en,
    input  logic                     second,
    input  logic [IDXW-1:0]          line_idx,
    input  logic [DRIVES-1:0]        line_en,
    input  logic [SENSES-1:0]        sense_in,
    output logic [DRIVES*SENSES-1:0] buf_a,
    output logic [DRIVES*SENSES-1:0] buf_b
);
    localparam int KEYS = DRIVES * SENSES;

    typedef struct packed {
        logic [KEYS-1:0] a;
        logic [KEYS-1:0] b;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        int base;
        logic [SENSES-1:0] slice;
        cap_d = cap_q;
        base  = int'(line_idx) * SENSES;
        slice = line_en[line_idx] ? sense_in : '0;
        if (cap_en) begin
            if (second) cap_d.b[base +: SENSES] = slice;
            else        cap_d.a[base +: SENSES] = slice;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign buf_a = cap_q.a;
    assign buf_b = cap_q.b;
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner #(
    parameter int DRIVES       = 6,
    parameter int SENSES       = 5,
    parameter int SCAN_PERIODS = 288,
    parameter int REQ_PERIODS  = 615
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [1:0]               sleep_code,
    input  logic [1:0]               line_sel,
    input  logic [SENSES-1:0]        sense_in,
    input  logic                     host_read,
    output logic [DRIVES-1:0]        drive_out,
    output logic [DRIVES*SENSES-1:0] key_data,
    output logic                     read_req,
    output logic                     osc_run
);
    import kms_pkg::*;

    localparam int KEYS  = DRIVES * SENSES;
    localparam int SLOT  = SCAN_PERIODS / DRIVES;
    localparam int HOLD  = REQ_PERIODS - 2 * SCAN_PERIODS;
    localparam int SW    = $clog2(SLOT + 1);
    localparam int LW    = $clog2(2 * DRIVES);
    localparam int HW    = $clog2(HOLD + 1);

    typedef struct packed {
        kms_state_e      st;
        logic [SW-1:0]   sub;
        logic [LW-1:0]   slot;
        logic [HW-1:0]   hold;
        logic            req;
        logic [KEYS-1:0] keys;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DRIVES-1:0] line_en, idle_drive;
    logic [KEYS-1:0]   buf_a, buf_b;
    logic [LW-1:0]     cur_line;
    logic              second, capture_en, in_scan;

    kms_line_map #(.DRIVES(DRIVES)) u_map (
        .line_sel   (line_sel),
        .sleep_code (sleep_code),
        .line_en    (line_en),
        .idle_drive (idle_drive)
    );

    assign second   = (ctl_q.slot >= LW'(DRIVES));
    assign cur_line = second ? ctl_q.slot - LW'(DRIVES) : ctl_q.slot;
    assign in_scan  = (ctl_q.st == ST_SCAN);

    kms_capture #(.DRIVES(DRIVES), .SENSES(SENSES), .IDXW(LW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (capture_en),
        .second   (second),
        .line_idx (cur_line),
        .line_en  (line_en),
        .sense_in (sense_in),
        .buf_a    (buf_a),
        .buf_b    (buf_b)
    );

    always_comb begin
        ctl_d      = ctl_q;
        capture_en = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (|sense_in) begin
                    ctl_d.st   = ST_SCAN;
                    ctl_d.sub  = '0;
                    ctl_d.slot = '0;
                end
            end
            ST_SCAN: begin
                if (tick) begin
                    if (ctl_q.sub == SW'(SLOT - 1)) begin
                        capture_en = 1'b1;
                        ctl_d.sub  = '0;
                        if (ctl_q.slot == LW'(2 * DRIVES - 1)) begin
                            ctl_d.st   = ST_HOLD;
                            ctl_d.hold = '0;
                        end else begin
                            ctl_d.slot = ctl_q.slot + 1'b1;
                        end
                    end else begin
                        ctl_d.sub = ctl_q.sub + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (ctl_q.hold == HW'(HOLD - 1)) begin
                        if (buf_a == buf_b) begin
                            ctl_d.keys = buf_a;
                            if (|buf_a) begin
                                ctl_d.st  = ST_WAIT;
                                ctl_d.req = 1'b1;
                            end else begin
                                ctl_d.st = ST_IDLE;
                            end
                        end else if (|sense_in) begin
                            ctl_d.st   = ST_SCAN;
                            ctl_d.sub  = '0;
                            ctl_d.slot = '0;
                        end else begin
                            ctl_d.st = ST_IDLE;
                        end
                    end else begin
                        ctl_d.hold = ctl_q.hold + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (host_read) begin
                    ctl_d.req  = 1'b0;
                    ctl_d.st   = ST_SCAN;
                    ctl_d.sub  = '0;
                    ctl_d.slot = '0;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        if (in_scan) drive_out = (DRIVES'(1) << cur_line) & line_en;
        else         drive_out = idle_drive;
    end

    assign key_data = ctl_q.keys;
    assign read_req = ctl_q.req;
    assign osc_run  = (sleep_code == 2'b00) || (ctl_q.st != ST_IDLE);
endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
    parameter int DRIVES = 6,
    parameter int KEYS   = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        sleep_code,
    input logic [1:0]        line_sel,
    input logic              host_read,
    input logic [DRIVES-1:0] drive_out,
    input logic [KEYS-1:0]   key_data,
    input logic              read_req,
    input logic              osc_run,
    input logic              in_scan
);
    assert_scan_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_scan |-> $onehot0(drive_out));

    assert_line2_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sel != 2'b00) |-> !drive_out[1]);

    assert_line1_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_sel[1] |-> !drive_out[0]);

    assert_normal_osc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_code == 2'b00) |-> osc_run);

    assert_req_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_req) |-> (key_data != '0));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (read_req && host_read) |=> !read_req);

    assert_reset_state_R12: assert property (@(posedge clk)
        $rose(rst_n) |-> (!read_req && key_data == '0));
endmodule

bind key_matrix_scanner kms_checker #(.DRIVES(DRIVES), .KEYS(KEYS)) u_kms_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_code (sleep_code),
    .line_sel   (line_sel),
    .host_read  (host_read),
    .drive_out  (drive_out),
    .key_data   (key_data),
    .read_req   (read_req),
    .osc_run    (osc_run),
    .in_scan    (in_scan)
);

// File: tb/key_matrix_scanner_bench.sv
module key_matrix_scanner_bench;
    localparam int REQ = 615;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic [1:0]  sleep_code = 2'b00;
    logic [1:0]  line_sel = 2'b00;
    logic [4:0]  sense_in;
    logic        host_read = 1'b0;
    logic [5:0]  drive_out;
    logic [29:0] key_data;
    logic        read_req;
    logic        osc_run;
    logic [29:0] keys = '0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    key_matrix_scanner u_key_matrix_scanner (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sleep_code(sleep_code),
        .line_sel(line_sel), .sense_in(sense_in), .host_read(host_read),
        .drive_out(drive_out), .key_data(key_data), .read_req(read_req),
        .osc_run(osc_run)
    );

    // switch matrix: a pressed key couples its drive line to its sense input
    always_comb begin
        sense_in = '0;
        for (int j = 0; j < 6; j++)
            for (int i = 0; i < 5; i++)
                if (drive_out[j] && keys[j*5+i]) sense_in[i] = 1'b1;
    end

    task automatic check(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_req(input int limit, output int n);
        int c = 0;
        n = -1;
        while (c < limit && n < 0) begin
            @(negedge clk);
            c++;
            if (read_req) n = c;
        end
    endtask

    task automatic read_pulse();
        host_read = 1'b1;
        @(negedge clk);
        host_read = 1'b0;
    endtask

    task automatic cleanup();
        keys = '0;
        if (read_req) read_pulse();
        repeat (REQ + 5) @(negedge clk);
    endtask

    function automatic bit line_on(input int line, input logic [1:0] sel);
        if (line == 0) return !sel[1];
        if (line == 1) return sel == 2'b00;
        return 1'b1;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state and idle hold
        check("R12 key_data after reset", key_data, 0);
        check("R12 read_req after reset", read_req, 0);
        repeat (50) @(negedge clk);
        check("R2 idle without sense", drive_out, 6'h3F);
        check("R1 normal idle pattern", drive_out, 6'h3F);
        check("R11 osc in normal idle", osc_run, 1);

        // read strobe with nothing pending is ignored
        read_pulse();
        repeat (5) @(negedge clk);
        check("R8 stray read keeps idle drive", drive_out, 6'h3F);
        check("R8 stray read no request", read_req, 0);

        // single key: line 3, sense 4 -> bit 13
        keys = 30'd1 << 13;
        wait_req(1000, n);
        check("R5 request latency", n, REQ + 1);
        check("R4 single key bit", key_data, 30'd1 << 13);
        read_pulse();
        check("R8 read clears request", read_req, 0);
        wait_req(1000, n);
        check("R8 rescan while held", n, REQ);
        // release, read, confirm all-zero
        keys = '0;
        read_pulse();
        wait_req(REQ + 20, n);
        check("R9 no request on release", n, -1);
        check("R9 key_data cleared", key_data, 0);
        check("R9 back to idle drive", drive_out, 6'h3F);

        // two keys at opposite corners
        keys = (30'd1 << 0) | (30'd1 << 29);
        wait_req(1000, n);
        check("R4 corner keys", key_data, (30'd1 << 0) | (30'd1 << 29));
        cleanup();

        // tick low stalls the scan
        tick = 1'b0;
        keys = 30'd1 << 7;
        repeat (100) @(negedge clk);
        check("R13 no request while tick low", read_req, 0);
        tick = 1'b1;
        wait_req(1000, n);
        check("R13 request after ticks resume", n, REQ);
        cleanup();

        // disagreement with key still down: rescan
        keys = 30'd1 << 15;
        repeat (300) @(negedge clk);
        keys = keys | 30'd1;
        wait_req(2000, n);
        check("R6 repeated scan latency", n + 300, 2 * REQ + 1);
        check("R6 data after repeat", key_data, (30'd1 << 15) | 30'd1);
        cleanup();

        // disagreement with release: back to idle
        keys = 30'd1 << 15;
        repeat (400) @(negedge clk);
        keys = '0;
        wait_req(900, n);
        check("R7 no request after disagree", n, -1);
        check("R7 key_data unchanged", key_data, 0);
        check("R7 idle drive restored", drive_out, 6'h3F);

        // reduced matrix: disabled line key plus enabled key
        line_sel = 2'b10;
        @(negedge clk);
        check("R10 idle drive with lines 1-2 off", drive_out, 6'h3C);
        keys = 30'd1 | (30'd1 << 10);
        wait_req(1000, n);
        check("R10 disabled bits read zero", key_data, 30'd1 << 10);
        cleanup();

        // sweep every key over the line-select codes
        for (int s = 0; s < 3; s++) begin
            int lim;
            line_sel = 2'(s);
            lim = (s == 0) ? 30 : 10;
            for (int k = 0; k < lim; k++) begin
                bit on;
                on = line_on(k / 5, line_sel);
                keys = 30'd1 << k;
                wait_req(REQ + 80, n);
                if (on) begin
                    check("R4 sweep latency", n, REQ + 1);
                    check("R4 sweep bit", key_data, 30'd1 << k);
                end else begin
                    check("R10 sweep disabled no request", n, -1);
                    check("R10 sweep disabled data", key_data, 0);
                end
                cleanup();
            end
        end
        line_sel = 2'b00;

        // sleep idle patterns
        sleep_code = 2'b01;
        @(negedge clk);
        check("R1 sleep 01 pattern", drive_out, 6'h20);
        check("R11 osc stopped in sleep idle", osc_run, 0);
        sleep_code = 2'b10;
        @(negedge clk);
        check("R1 sleep 10 pattern", drive_out, 6'h30);
        sleep_code = 2'b11;
        @(negedge clk);
        check("R1 sleep 11 pattern", drive_out, 6'h3F);

        // sleep 01: press on line 6 wakes, press on line 1 does not
        sleep_code = 2'b01;
        keys = 30'd1 << 25;
        repeat (10) @(negedge clk);
        check("R11 osc runs during sleep scan", osc_run, 1);
        wait_req(1000, n);
        check("R5 sleep wake latency", n + 10, REQ + 1);
        check("R4 sleep wake bit", key_data, 30'd1 << 25);
        cleanup();
        keys = 30'd1 << 2;
        wait_req(REQ + 80, n);
        check("R2 undriven line does not wake", n, -1);
        check("R11 osc still stopped", osc_run, 0);
        cleanup();
        sleep_code = 2'b00;

        // reset while a request is pending
        keys = 30'd1 << 20;
        wait_req(1000, n);
        check("R5 request before reset", read_req, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 reset clears request", read_req, 0);
        check("R12 reset clears keys", key_data, 0);
        keys = '0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule